// File: doc/BRIEF.md
# Ten-Step Parallel LFSR Word Generator

This block delivers a fresh 10-bit pseudo-random word on every enabled clock. Inside it sits a 31-bit binary linear feedback shift register. Each enabled cycle moves the register forward by ten single-bit shift steps at once. The combinational next-state logic is the bit-serial update copied ten times into one XOR network. Because the register moves ten places per word, no bit of one word is a shifted copy of a bit in the word before it. Taking the low bits of a register that moves one place per clock would make every word almost fully predictable from the previous one.

A compile-time parameter picks the register form. In the external-feedback form, the XOR of the tap bits enters at the shift input. In the internal-feedback form, the bit that leaves the register is XORed into the tap positions. Both forms follow the feedback polynomial x^31 + x^28 + 1, so each gives a stream of period 2^31 - 1. With the same seed, the two forms do not hold the same register contents at a given step.

The user loads a seed through a load strobe. A seed of zero would lock the register, so the block replaces it with a fixed nonzero constant.

Top module: `prng_word_gen`

## Requirements
- R1: On each rising edge where `enable` is high and `seedLoad` is low, the register advances exactly ten single-bit steps. `word` takes the ten bits shifted out of the register's MSB (bit 30) during those steps. The first step's bit goes to `word[9]` and the last step's bit goes to `word[0]`.
- R2: External form (`EXT_FORM`=1, the default). One step shifts the register left by one place. The new bit 0 is the old bit 30 XOR the old bit 27.
- R3: Internal form (`EXT_FORM`=0). One step shifts the register left by one place and puts 0 in bit 0. If the old bit 30 was 1, the result is then XORed with 31'h1000_0001, which flips bit 28 and bit 0.
- R4: In the external form, the first two words after loading seed S are exactly S[30:21] and then S[20:11]. Consecutive words therefore share no shifted bits.
- R5: A synchronous reset (`rst` high at a rising edge) sets the register to the fallback value 31'h0000_ACE1, `word` to 0 and `wordValid` to 0.
- R6: `seedLoad` high at a rising edge loads `seedValue` into the register and clears `wordValid`. It leaves `word` unchanged. If `enable` is high in the same cycle, the load takes priority and the register does not advance.
- R7: Loading an all-zero seed loads the fallback value 31'h0000_ACE1 instead. For example, the second word after such a load in the external form is 10'h015.
- R8: `wordValid` goes to 1 at the first enabled edge after a reset or a load. It stays at 1 through later enabled edges.
- R9: While `enable` and `seedLoad` are both low, the register, `word` and `wordValid` keep their values.
- R10: After reset, the register never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| seedLoad | input | 1 | Load strobe for the seed |
| seedValue | input | 31 | Seed to load (zero is replaced by the fallback value) |
| enable | input | 1 | Advance the register by ten steps and produce a word |
| word | output | 10 | Latest pseudo-random word |
| wordValid | output | 1 | Set once a word has been produced since the last reset or load |

## Verification
Every result in this block is registered once. A word, a register load and a valid change each appear one rising edge after the stimulus that causes them, and nothing takes longer. The bench drives inputs on the falling edge. It updates its bit-serial reference model at the next rising edge and compares 1 ns later, so each comparison sees exactly the edge it predicts. Words that hold while `enable` is low are compared on each idle cycle, which catches any output that changes when it should not.

// File: rtl/prng_pkg.sv
package prng_pkg;
  // Per-cycle commands from control to datapath.
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } prng_strobe_t;
endpackage

// File: rtl/prng_step.sv
// Combinational ten-step unroll of the bit-serial LFSR update.
module prng_step #(
  parameter int STATE_W  = 31,
  parameter int WORD_W   = 10,
  parameter int TAP_POS  = 28,
  parameter bit EXT_FORM = 1'b1
) (
  input  logic [STATE_W-1:0] stateIn,
  output logic [STATE_W-1:0] stateOut,
  output logic [WORD_W-1:0]  bitsOut
);
  localparam logic [STATE_W-1:0] ONE_W   = {{(STATE_W-1){1'b0}}, 1'b1};
  localparam logic [STATE_W-1:0] FB_MASK = (ONE_W << TAP_POS) | ONE_W;

  logic [STATE_W-1:0] chain [WORD_W+1];

  assign chain[0]  = stateIn;
  assign stateOut  = chain[WORD_W];

  for (genvar k = 0; k < WORD_W; k++) begin : g_stage
    // Serial output bit of step k is the MSB before the shift.
    assign bitsOut[WORD_W-1-k] = chain[k][STATE_W-1];
    if (EXT_FORM) begin : g_ext
      assign chain[k+1] = {chain[k][STATE_W-2:0],
                           chain[k][STATE_W-1] ^ chain[k][TAP_POS-1]};
    end else begin : g_int
      assign chain[k+1] = {chain[k][STATE_W-2:0], 1'b0}
                          ^ (chain[k][STATE_W-1] ? FB_MASK : '0);
    end
  end
endmodule

// File: rtl/prng_ctrl.sv
// Control: strobe decode and word-valid tracking.
module prng_ctrl
  import prng_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         seedLoad,
  input  logic         enable,
  output prng_strobe_t strobe,
  output logic         wordValid
);
  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.advance  = enable & ~seedLoad;   // load has priority
  end

  always_ff @(posedge clk) begin
    if (rst)                 wordValid <= 1'b0;
    else if (seedLoad)       wordValid <= 1'b0;
    else if (enable)         wordValid <= 1'b1;
  end

  a_r5_reset_valid: assert property (@(posedge clk) rst |=> !wordValid);
  a_r6_load_clears: assert property (@(posedge clk) disable iff (rst)
    seedLoad |=> !wordValid);
  a_r8_valid_rise: assert property (@(posedge clk) disable iff (rst)
    (enable && !seedLoad) |=> wordValid);
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
    (!enable && !seedLoad) |=> $stable(wordValid));
endmodule

// File: rtl/prng_datapath.sv
// Datapath: state register, zero-seed guard, output word register.
module prng_datapath
  import prng_pkg::*;
#(
  parameter int                 STATE_W       = 31,
  parameter int                 WORD_W        = 10,
  parameter int                 TAP_POS       = 28,
  parameter bit                 EXT_FORM      = 1'b1,
  parameter logic [STATE_W-1:0] FALLBACK_SEED = 31'h0000_ACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  prng_strobe_t       strobe,
  input  logic [STATE_W-1:0] seedValue,
  output logic [WORD_W-1:0]  word
);
  logic [STATE_W-1:0] stateQ, stateNext, seedSafe;
  logic [WORD_W-1:0]  stepBits;

  prng_step #(
    .STATE_W (STATE_W),
    .WORD_W  (WORD_W),
    .TAP_POS (TAP_POS),
    .EXT_FORM(EXT_FORM)
  ) u_step (
    .stateIn (stateQ),
    .stateOut(stateNext),
    .bitsOut (stepBits)
  );

  assign seedSafe = (seedValue == '0) ? FALLBACK_SEED : seedValue;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= FALLBACK_SEED;
      word   <= '0;
    end else if (strobe.loadSeed) begin
      stateQ <= seedSafe;
    end else if (strobe.advance) begin
      stateQ <= stateNext;
      word   <= stepBits;
    end
  end

  a_r10_never_zero: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);
  a_r9_state_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadSeed && !strobe.advance) |=> ($stable(stateQ) && $stable(word)));
  a_r6_load_seed: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSeed && seedValue != '0) |=> (stateQ == $past(seedValue) && $stable(word)));
  a_r7_zero_seed: assert property (@(posedge clk) disable iff (rst)
    (strobe.loadSeed && seedValue == '0) |=> stateQ == FALLBACK_SEED);
endmodule

// File: rtl/prng_word_gen.sv
module prng_word_gen
  import prng_pkg::*;
#(
  parameter int                 STATE_W       = 31,
  parameter int                 WORD_W        = 10,
  parameter int                 TAP_POS       = 28,
  parameter bit                 EXT_FORM      = 1'b1,
  parameter logic [STATE_W-1:0] FALLBACK_SEED = 31'h0000_ACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seedLoad,
  input  logic [STATE_W-1:0] seedValue,
  input  logic               enable,
  output logic [WORD_W-1:0]  word,
  output logic               wordValid
);
  prng_strobe_t strobe;

  prng_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .enable   (enable),
    .strobe   (strobe),
    .wordValid(wordValid)
  );

  prng_datapath #(
    .STATE_W      (STATE_W),
    .WORD_W       (WORD_W),
    .TAP_POS      (TAP_POS),
    .EXT_FORM     (EXT_FORM),
    .FALLBACK_SEED(FALLBACK_SEED)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .seedValue(seedValue),
    .word     (word)
  );
endmodule

// File: tb/prng_word_gen_test.sv
module prng_word_gen_test;
  localparam logic [30:0] FALLBACK = 31'h0000_ACE1;
  localparam logic [30:0] GMASK    = 31'h1000_0001;

  typedef struct packed {
    logic        ld;
    logic [30:0] seed;
    logic        en;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 31'h2AA7_8000, 1'b0},  // R6 load
    '{1'b0, 31'h0,         1'b1},  // R1 R8
    '{1'b0, 31'h0,         1'b1},
    '{1'b0, 31'h0,         1'b0},  // R9 idle
    '{1'b0, 31'h0,         1'b1},
    '{1'b1, 31'h1234_5678, 1'b1},  // R6 load beats enable
    '{1'b0, 31'h0,         1'b1},
    '{1'b1, 31'h0,         1'b0},  // R7 zero seed
    '{1'b0, 31'h0,         1'b1},
    '{1'b0, 31'h0,         1'b1},
    '{1'b0, 31'h0,         1'b0},
    '{1'b0, 31'h0,         1'b0},
    '{1'b1, 31'h7FFF_FFFF, 1'b1},
    '{1'b0, 31'h0,         1'b1},  // R2 R3
    '{1'b0, 31'h0,         1'b1},
    '{1'b0, 31'h0,         1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seedLoad = 1'b0;
  logic [30:0] seedValue = '0;
  logic        enable = 1'b0;
  logic [9:0]  wordE, wordG;
  logic        validE, validG;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [30:0] refE, refG;
  logic [9:0]  refWordE, refWordG;
  logic        refValid;

  always #2 clk = ~clk;

  prng_word_gen #(.EXT_FORM(1'b1)) uut (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .enable(enable), .word(wordE), .wordValid(validE));

  prng_word_gen #(.EXT_FORM(1'b0)) uutGal (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .seedValue(seedValue),
    .enable(enable), .word(wordG), .wordValid(validG));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-serial reference: one step at a time, ten per enabled edge.
  task automatic model_edge(input logic ld, input logic [30:0] sd, input logic en);
    if (ld) begin
      refE = (sd == 31'h0) ? FALLBACK : sd;
      refG = refE;
      refValid = 1'b0;
    end else if (en) begin
      for (int i = 0; i < 10; i++) begin
        logic mE, mG;
        mE = refE[30];
        mG = refG[30];
        refWordE[9-i] = mE;
        refWordG[9-i] = mG;
        refE = {refE[29:0], refE[30] ^ refE[27]};
        refG = {refG[29:0], 1'b0} ^ (mG ? GMASK : 31'h0);
      end
      refValid = 1'b1;
    end
  endtask

  task automatic model_reset();
    refE = FALLBACK; refG = FALLBACK;
    refWordE = '0; refWordG = '0; refValid = 1'b0;
  endtask

  // Drive at negedge, step model at posedge, compare 1 ns later.
  task automatic apply(input logic ld, input logic [30:0] sd, input logic en, input string tag);
    @(negedge clk);
    seedLoad = ld; seedValue = sd; enable = en;
    @(posedge clk);
    model_edge(ld, sd, en);
    #1;
    check({tag, " ext word"}, {22'h0, wordE}, {22'h0, refWordE});
    check({tag, " int word"}, {22'h0, wordG}, {22'h0, refWordG});
    check({tag, " valid"}, {30'h0, validG, validE}, {30'h0, refValid, refValid});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; seedLoad = 1'b0; enable = 1'b1;
    @(posedge clk);
    model_reset();
    #1;
    check("R5 reset word", {12'h0, wordE, wordG}, 32'h0);
    check("R5 reset valid", {30'h0, validE, validG}, 32'h0);
    @(negedge clk);
    rst = 1'b0; enable = 1'b0;
  endtask

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    check("R5 initial reset", {20'h0, wordE, validE, wordG[8:0]}, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3: first enabled edge after reset starts from fallback.
    apply(1'b0, 31'h0, 1'b1, "R1 from fallback");

    // Vector table walk.
    for (int v = 0; v < NV; v++)
      apply(VECS[v].ld, VECS[v].seed, VECS[v].en, "R1 R8 R9 table");

    // R4: words are disjoint fields of the seed in the external form.
    apply(1'b1, 31'h2AA7_8000, 1'b0, "R6 load");
    apply(1'b0, 31'h0, 1'b1, "R4 word1");
    check("R4 first word", {22'h0, wordE}, 32'h155);
    apply(1'b0, 31'h0, 1'b1, "R4 word2");
    check("R4 second word", {22'h0, wordE}, 32'h0F0);

    // R7: zero seed uses the fallback, second word is 10'h015.
    apply(1'b1, 31'h0, 1'b1, "R7 zero load");
    check("R7 valid cleared", {31'h0, validE}, 32'h0);
    apply(1'b0, 31'h0, 1'b1, "R7 word1");
    apply(1'b0, 31'h0, 1'b1, "R7 word2");
    check("R7 second word", {22'h0, wordE}, 32'h015);

    // R9: long idle keeps word and valid.
    for (int i = 0; i < 5; i++) apply(1'b0, 31'h0, 1'b0, "R9 idle");
    check("R9 held word", {22'h0, wordE}, 32'h015);

    // R5: reset in mid-run, then restart.
    do_reset();
    apply(1'b0, 31'h0, 1'b1, "R5 restart");

    // R2 R3 R10: long enabled run against the serial model.
    apply(1'b1, 31'h5A5A_1234, 1'b0, "R6 load");
    for (int i = 0; i < 300; i++) apply(1'b0, 31'h0, 1'b1, "R2 R3 R10 run");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule